// File: doc/BRIEF.md
# Stereo Four-Channel Audio Mixer

The mixer takes four unsigned 4-bit channel levels and forms a left output and a right output. Each channel has two switches, one per side, held in a single 8-bit routing register. A side's output is the plain sum of the channels switched onto it. A channel whose switch is open adds nothing to that side.

Each side's sum is then multiplied by that side's 3-bit master volume plus one, so the gain ranges from 1 to 8. The two volumes share an 8-bit master register with two enable flags for an external audio input. Those flags are only stored and read back; they never reach the mix. Software writes and reads both registers through a small port. The outputs are registered, and a global power enable forces both of them to zero.

Top module: `stereo_mixer`

## Requirements
- R1: After reset, both registers read 0x00 and both outputs are 0.
- R2: A write with `wr_sel`=0 loads the routing register, and `wr_sel`=1 loads the master register. `rd_data` shows the register chosen by `rd_sel` (same encoding) and returns exactly the last value written. A register holds its value while no write is made to it.
- R3: Routing register bit k (k=0..3) switches channel k+1 onto the left output. Bit k+4 switches channel k+1 onto the right output. Channel k+1 is `ch_lvl[4k+3:4k]`.
- R4: A channel whose switch for a side is clear contributes 0 to that side. With no channel switched on, the side outputs 0.
- R5: Each side outputs (sum of its routed levels) × (volume + 1). The left volume is master bits 6..4 and the right volume is master bits 2..0.
- R6: Master bit 7 (left external enable) and bit 3 (right external enable) are stored and read back, and have no effect on either output.
- R7: Outputs change one clock edge after a channel level changes, and two edges after the write edge of a register, since the register itself takes one edge.
- R8: While `pwr_en` is low, both outputs are 0 one edge later. Register contents are kept, and the mix returns when power comes back.
- R9: The full-scale result, four levels of 15 at volume 7, gives exactly 480 on a 9-bit output without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_en | input | 1 | Global power enable; low forces outputs to zero |
| ch_lvl | input | 16 | Four packed 4-bit channel levels, channel 1 in bits 3..0 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 routing, 1 master |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 routing, 1 master |
| rd_data | output | 8 | Read data, combinational from the selected register |
| out_left | output | 9 | Registered left mix |
| out_right | output | 9 | Registered right mix |

## Verification
A channel-level change shows on the outputs after one rising edge. A register write shows on `rd_data` after its own write edge, but reaches the outputs only after a second edge. The bench drives every input on the falling edge and samples on a later falling edge, exactly one rising edge after the last level or register change. The latency checks also sample before that edge to confirm that the old value is still present. They also read the register back in the cycle between the write and the output change.

// File: rtl/stereo_mix_pkg.sv
package stereo_mix_pkg;
  parameter int unsigned CH_N    = 4;
  parameter int unsigned LVL_W   = 4;
  parameter int unsigned VOL_W   = 3;
  parameter int unsigned REG_W   = 8;
  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;
  localparam int unsigned SUM_MAX = CH_N * LVL_MAX;
  localparam int unsigned SUM_W   = $clog2(SUM_MAX + 1);
  localparam int unsigned OUT_MAX = SUM_MAX * (1 << VOL_W);
  localparam int unsigned OUT_W   = $clog2(OUT_MAX + 1);

  typedef enum logic { SEL_ROUTE = 1'b0, SEL_MASTER = 1'b1 } reg_sel_e;

  // sum of the channel levels whose mask bit is set
  function automatic logic [SUM_W-1:0] lane_sum(
    input logic [CH_N*LVL_W-1:0] lv,
    input logic [CH_N-1:0]       mask
  );
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < CH_N; i++) begin
      if (mask[i]) acc = acc + SUM_W'(lv[i*LVL_W +: LVL_W]);
    end
    return acc;
  endfunction

  // gain of (volume + 1)
  function automatic logic [OUT_W-1:0] apply_gain(
    input logic [SUM_W-1:0] sum,
    input logic [VOL_W-1:0] vol
  );
    return OUT_W'(sum) * (OUT_W'(vol) + OUT_W'(1));
  endfunction
endpackage

// File: rtl/mix_regs.sv
module mix_regs
  import stereo_mix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] route_q,
  output logic [REG_W-1:0] master_q
);
  logic route_we, master_we;
  assign route_we  = wr_en && (wr_sel == SEL_ROUTE);
  assign master_we = wr_en && (wr_sel == SEL_MASTER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q  <= '0;
      master_q <= '0;
    end else begin
      if (route_we)  route_q  <= wr_data;
      if (master_we) master_q <= wr_data;
    end
  end

  assign rd_data = (rd_sel == SEL_MASTER) ? master_q : route_q;

  assert_hold_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !route_we |=> $stable(route_q));
  assert_hold_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !master_we |=> $stable(master_q));
endmodule

// File: rtl/mix_lane.sv
module mix_lane
  import stereo_mix_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_en,
  input  logic [CH_N*LVL_W-1:0] levels,
  input  logic [CH_N-1:0]       mask,
  input  logic [VOL_W-1:0]      vol,
  output logic [OUT_W-1:0]      lane_q
);
  logic [SUM_W-1:0] sum_w;
  logic [OUT_W-1:0] gain_w;
  logic [OUT_W-1:0] scaled_w;

  assign sum_w    = lane_sum(levels, mask);
  assign gain_w   = OUT_W'(vol) + OUT_W'(1);
  assign scaled_w = apply_gain(sum_w, vol);

  always_ff @(posedge clk) begin
    if (!rst_n)       lane_q <= '0;
    else if (!pwr_en) lane_q <= '0;
    else              lane_q <= scaled_w;
  end

  assert_silent_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> (lane_q == '0));
  assert_gain_multiple_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_en) |-> ((lane_q % $past(gain_w)) == '0));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lane_q <= OUT_W'(OUT_MAX));
endmodule

// File: rtl/stereo_mixer.sv
module stereo_mixer
  import stereo_mix_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_en,
  input  logic [CH_N*LVL_W-1:0] ch_lvl,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  rd_sel,
  output logic [REG_W-1:0]      rd_data,
  output logic [OUT_W-1:0]      out_left,
  output logic [OUT_W-1:0]      out_right
);
  localparam int unsigned SIDES   = 2;
  localparam int unsigned FIELD_W = VOL_W + 1;

  logic [REG_W-1:0] route_q, master_q;
  logic [OUT_W-1:0] lane_out [SIDES];

  mix_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .route_q  (route_q),
    .master_q (master_q)
  );

  // side 0 = left: low route nibble, upper master field
  // side 1 = right: high route nibble, lower master field
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int unsigned VOL_LSB = (SIDES - 1 - s) * FIELD_W;
    mix_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_en (pwr_en),
      .levels (ch_lvl),
      .mask   (route_q[s*CH_N +: CH_N]),
      .vol    (master_q[VOL_LSB +: VOL_W]),
      .lane_q (lane_out[s])
    );
  end

  assign out_left  = lane_out[0];
  assign out_right = lane_out[1];

  assert_power_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (out_left == '0 && out_right == '0));
endmodule

// File: tb/stereo_mixer_bench.sv
module stereo_mixer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_en;
  logic [15:0] ch_lvl;
  logic       wr_en, wr_sel, rd_sel;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [8:0] out_left, out_right;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  stereo_mixer u_stereo_mixer (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .ch_lvl(ch_lvl),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .out_left(out_left), .out_right(out_right)
  );

  // {route, master, levels, expect_left, expect_right}
  localparam int NV = 8;
  localparam logic [49:0] VEC [NV] = '{
    {8'hFF, 8'h77, 16'hFFFF, 9'd480, 9'd480},
    {8'h00, 8'h77, 16'hFFFF, 9'd0,   9'd0},
    {8'h0F, 8'h00, 16'h4321, 9'd10,  9'd0},
    {8'hF0, 8'h07, 16'h4321, 9'd0,   9'd80},
    {8'h21, 8'h52, 16'hFF95, 9'd30,  9'd27},
    {8'h84, 8'hB1, 16'h7300, 9'd12,  9'd14},
    {8'h5A, 8'h3C, 16'h8421, 9'd40,  9'd25},
    {8'h88, 8'h88, 16'hC000, 9'd12,  9'd12}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic sel, input int exp);
    rd_sel = sel;
    #1;
    chk(req, int'(rd_data), exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_en = 1'b1; ch_lvl = 16'hFFFF;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00; rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 left", int'(out_left), 0);
    chk("R1 right", int'(out_right), 0);
    rd_chk("R1 route", 1'b0, 0);
    rd_chk("R1 master", 1'b1, 0);

    // table walk: R2 R3 R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, VEC[i][49:42]);
      wr(1'b1, VEC[i][41:34]);
      ch_lvl = VEC[i][33:18];
      @(negedge clk);
      rd_chk("R2 route", 1'b0, int'(VEC[i][49:42]));
      rd_chk("R2 master", 1'b1, int'(VEC[i][41:34]));
      chk($sformatf("R3 R4 R5 R9 left v%0d", i), int'(out_left), int'(VEC[i][17:9]));
      chk($sformatf("R3 R4 R5 R9 right v%0d", i), int'(out_right), int'(VEC[i][8:0]));
    end

    // R7 level latency (route 0x88, master 0x88, gain 1)
    @(negedge clk);
    ch_lvl = 16'h3000;
    #5;
    chk("R7 before edge", int'(out_left), 12);
    @(negedge clk);
    chk("R7 after edge left", int'(out_left), 3);
    chk("R7 after edge right", int'(out_right), 3);

    // R7 register write latency
    wr(1'b0, 8'h08);
    rd_chk("R7 readback at write", 1'b0, 8'h08);
    chk("R7 right still old", int'(out_right), 3);
    @(negedge clk);
    chk("R7 right after second edge", int'(out_right), 0);
    chk("R7 left kept", int'(out_left), 3);

    // R6 external enable bits have no effect
    wr(1'b1, 8'h00);
    @(negedge clk);
    chk("R6 left ext off", int'(out_left), 3);
    wr(1'b1, 8'h88);
    @(negedge clk);
    rd_chk("R6 readback", 1'b1, 8'h88);
    chk("R6 left ext on", int'(out_left), 3);
    chk("R6 right ext on", int'(out_right), 0);

    // R8 power gating
    pwr_en = 1'b0;
    @(negedge clk);
    chk("R8 left off", int'(out_left), 0);
    rd_chk("R8 route kept", 1'b0, 8'h08);
    pwr_en = 1'b1;
    @(negedge clk);
    chk("R8 left restored", int'(out_left), 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule